// File: doc/BRIEF.md
# Flash Program/Erase Pulse Sequencer

This block drives the program and erase of one flash storage location with a closed loop of timed pulses. After a start strobe it raises a pulse-enable line for a configured number of clock cycles and drops it. It then waits a settling delay and strobes a verify cycle, in which it compares the readback data with a target value. A location that has not yet reached the target gets another pulse, up to a configured maximum. A location that matches gets a configured number of extra margin pulses before the sequence reports done. If every allowed pulse is spent and the location never matches, the sequence reports fail.

The mode input selects program or erase. Each mode has its own pulse length and its own settling delay, all counted in clock cycles with 16-bit values. The whole configuration is captured on the start strobe and held for the rest of the sequence. The surrounding logic switches the high-voltage supply from the pulse-enable line and keeps ordinary array reads away while busy is high.

Top module: `fpe_pulse_seq`

## Requirements
- R1: While reset is high, and in the cycle after any clock edge that samples reset high, pulse_en_o, verify_o, busy_o, done_o and fail_o are all 0. This holds even if reset arrives in the middle of a sequence.
- R2: A start_i sampled high while the block is idle (busy_o, done_o and fail_o all 0) makes busy_o and pulse_en_o 1 in the next cycle.
- R3: Each pulse holds pulse_en_o high for prog_len_i consecutive cycles when erase_i was 0 at start, or for erase_len_i cycles when erase_i was 1. A length of 0 acts as 1.
- R4: After each verify-phase pulse, pulse_en_o stays low for a settle delay (prog_dly_i or erase_dly_i, chosen by mode, with 0 acting as 1) and then verify_o is high for exactly one cycle. verify_o is never high in the cycle right after pulse_en_o was high.
- R5: In the verify cycle, rd_data_i is compared with target_i. A match ends the verify phase. A mismatch with pulses left starts another pulse in the next cycle.
- R6: After the first match, exactly margin_i further pulses follow, each at the mode's pulse length and followed by its settle delay, with no verify strobe. Then done_o rises. With margin_i = 0, done_o follows the matching verify cycle directly.
- R7: At most max_pulses_i verify-phase pulses are applied, with 0 acting as 1. A mismatch in the verify cycle of the last allowed pulse raises fail_o in the next cycle, and pulse_en_o stays low.
- R8: done_o and fail_o are each one-cycle pulses. busy_o is 0 in that cycle, and in the following cycle the block is idle. done_o and fail_o are never high together.
- R9: start_i is ignored while busy_o is 1 and in the done_o or fail_o cycle. It changes neither the pulse count nor the timing of the sequence in progress.
- R10: All configuration inputs and target_i are captured on the accepted start. Changing them during the sequence has no effect on pulses, verifies or outcome.
- R11: pulse_en_o is high only while busy_o is high, and never in the same cycle as verify_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, used only when idle |
| erase_i | input | 1 | 0 = program, 1 = erase; captured at start |
| prog_len_i | input | 16 | Program pulse length in cycles |
| erase_len_i | input | 16 | Erase pulse length in cycles |
| prog_dly_i | input | 16 | Program settle delay before verify, in cycles |
| erase_dly_i | input | 16 | Erase settle delay before verify, in cycles |
| max_pulses_i | input | CNT_W | Maximum verify-phase pulses |
| margin_i | input | CNT_W | Margin pulses after first match |
| target_i | input | DATA_W | Value the location must read back |
| rd_data_i | input | DATA_W | Readback data, sampled in the verify cycle |
| pulse_en_o | output | 1 | High-voltage pulse enable |
| verify_o | output | 1 | Verify strobe, one cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |

## Verification
The bench builds the block with its default parameters: DATA_W = 8, CNT_W = 8 and 16-bit timing values. Because pulse lengths and delays are inputs and not parameters, small values such as 0, 1 and single digits keep every sequence to a few dozen cycles. That makes the boundary cases cheap to reach: zero lengths and counts acting as one, a match on exactly the last allowed pulse, running out of pulses, and margin counts of zero and above. A behavioural cell model lets each case set how many pulses the location needs before it reads back the target. The bench can then predict the exact done or fail cycle, the pulse and verify counts, and each pulse width and settle gap.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    localparam int unsigned TIME_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PULSE  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_VERIFY = 3'd3,
        ST_DONE   = 3'd4,
        ST_FAIL   = 3'd5
    } seq_state_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic [TIME_W-1:0] pulse_len;
        logic [TIME_W-1:0] settle_len;
    } time_cfg_t;

    // Zero-length intervals behave as a single cycle.
    function automatic logic [TIME_W-1:0] at_least_one(input logic [TIME_W-1:0] v);
        return (v == '0) ? TIME_W'(1) : v;
    endfunction

    function automatic logic [TIME_W-1:0] pick_len(input op_mode_e m,
                                                   input logic [TIME_W-1:0] prog_v,
                                                   input logic [TIME_W-1:0] erase_v);
        return at_least_one((m == OP_ERASE) ? erase_v : prog_v);
    endfunction

endpackage

// File: rtl/fpe_cycle_timer.sv
module fpe_cycle_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    // The last cycle of an interval of load_val cycles.
    assign expire = (cnt_q == W'(1));
endmodule

// File: rtl/fpe_cfg_hold.sv
module fpe_cfg_hold
    import fpe_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              erase,
    input  logic [TIME_W-1:0] plen,
    input  logic [TIME_W-1:0] elen,
    input  logic [TIME_W-1:0] pdly,
    input  logic [TIME_W-1:0] edly,
    input  logic [CNT_W-1:0]  max_in,
    input  logic [CNT_W-1:0]  margin_in,
    input  logic [DATA_W-1:0] target_in,
    output time_cfg_t         tcfg,
    output logic [CNT_W-1:0]  max_q,
    output logic [CNT_W-1:0]  margin_q,
    output logic [DATA_W-1:0] target_q
);
    op_mode_e mode_in;
    assign mode_in = op_mode_e'(erase);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcfg     <= '{pulse_len: TIME_W'(1), settle_len: TIME_W'(1)};
            max_q    <= CNT_W'(1);
            margin_q <= '0;
            target_q <= '0;
        end else if (load) begin
            tcfg.pulse_len  <= pick_len(mode_in, plen, elen);
            tcfg.settle_len <= pick_len(mode_in, pdly, edly);
            max_q           <= (max_in == '0) ? CNT_W'(1) : max_in;
            margin_q        <= margin_in;
            target_q        <= target_in;
        end
    end
endmodule

// File: rtl/fpe_pulse_tally.sv
module fpe_pulse_tally #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bump,
    input  logic             arm,
    input  logic             tick,
    input  logic [CNT_W-1:0] max_in,
    input  logic [CNT_W-1:0] margin_in,
    output logic             at_max,
    output logic             in_margin,
    output logic             margin_last
);
    logic [CNT_W-1:0] npulse_q;
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            npulse_q  <= '0;
            left_q    <= '0;
            in_margin <= 1'b0;
        end else begin
            if (bump) begin
                npulse_q <= npulse_q + CNT_W'(1);
            end
            if (arm) begin
                in_margin <= 1'b1;
                left_q    <= margin_in;
            end else if (tick && left_q != '0) begin
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

    assign at_max      = (npulse_q >= max_in);
    assign margin_last = (left_q == CNT_W'(1));
endmodule

// File: rtl/fpe_pulse_seq.sv
module fpe_pulse_seq
    import fpe_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              erase_i,
    input  logic [15:0]       prog_len_i,
    input  logic [15:0]       erase_len_i,
    input  logic [15:0]       prog_dly_i,
    input  logic [15:0]       erase_dly_i,
    input  logic [CNT_W-1:0]  max_pulses_i,
    input  logic [CNT_W-1:0]  margin_i,
    input  logic [DATA_W-1:0] target_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              pulse_en_o,
    output logic              verify_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o
);
    seq_state_e        st_q, st_d;
    time_cfg_t         tcfg;
    logic [CNT_W-1:0]  max_q, margin_q;
    logic [DATA_W-1:0] target_q;
    logic              cfg_load, tally_clr, bump, arm, tick;
    logic              at_max, in_margin, margin_last;
    logic              tmr_load, tmr_expire;
    logic [TIME_W-1:0] tmr_val;
    logic              match;

    fpe_cfg_hold #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (cfg_load),
        .erase     (erase_i),
        .plen      (prog_len_i),
        .elen      (erase_len_i),
        .pdly      (prog_dly_i),
        .edly      (erase_dly_i),
        .max_in    (max_pulses_i),
        .margin_in (margin_i),
        .target_in (target_i),
        .tcfg      (tcfg),
        .max_q     (max_q),
        .margin_q  (margin_q),
        .target_q  (target_q)
    );

    fpe_cycle_timer #(.W(TIME_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    fpe_pulse_tally #(.CNT_W(CNT_W)) u_tally (
        .clk         (clk),
        .rst         (rst),
        .clr         (tally_clr),
        .bump        (bump),
        .arm         (arm),
        .tick        (tick),
        .max_in      (max_q),
        .margin_in   (margin_q),
        .at_max      (at_max),
        .in_margin   (in_margin),
        .margin_last (margin_last)
    );

    assign match = (rd_data_i == target_q);

    always_comb begin
        st_d      = st_q;
        cfg_load  = 1'b0;
        tally_clr = 1'b0;
        bump      = 1'b0;
        arm       = 1'b0;
        tick      = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = tcfg.pulse_len;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d      = ST_PULSE;
                    cfg_load  = 1'b1;
                    tally_clr = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = pick_len(op_mode_e'(erase_i), prog_len_i, erase_len_i);
                end
            end
            ST_PULSE: begin
                if (tmr_expire) begin
                    st_d     = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = tcfg.settle_len;
                    bump     = !in_margin;
                end
            end
            ST_SETTLE: begin
                if (tmr_expire) begin
                    if (in_margin) begin
                        tick = 1'b1;
                        if (margin_last) begin
                            st_d = ST_DONE;
                        end else begin
                            st_d     = ST_PULSE;
                            tmr_load = 1'b1;
                        end
                    end else begin
                        st_d = ST_VERIFY;
                    end
                end
            end
            ST_VERIFY: begin
                if (match) begin
                    if (margin_q == '0) begin
                        st_d = ST_DONE;
                    end else begin
                        arm      = 1'b1;
                        st_d     = ST_PULSE;
                        tmr_load = 1'b1;
                    end
                end else if (at_max) begin
                    st_d = ST_FAIL;
                end else begin
                    st_d     = ST_PULSE;
                    tmr_load = 1'b1;
                end
            end
            ST_DONE, ST_FAIL: st_d = ST_IDLE;
            default:          st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_en_o = (st_q == ST_PULSE);
    assign verify_o   = (st_q == ST_VERIFY);
    assign busy_o     = (st_q == ST_PULSE) || (st_q == ST_SETTLE) || (st_q == ST_VERIFY);
    assign done_o     = (st_q == ST_DONE);
    assign fail_o     = (st_q == ST_FAIL);
endmodule

// File: rtl/fpe_pulse_seq_chk.sv
module fpe_pulse_seq_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic pulse_en_o,
    input logic verify_o,
    input logic busy_o,
    input logic done_o,
    input logic fail_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !pulse_en_o && !verify_o && !busy_o && !done_o && !fail_o);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !done_o && !fail_o) |=> (busy_o && pulse_en_o));

    // R4
    settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        verify_o |-> !$past(pulse_en_o));

    // R8
    end_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o || fail_o) |-> (!busy_o && !(done_o && fail_o)));

    // R8
    end_single_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o || fail_o) |=> (!done_o && !fail_o && !busy_o));

    // R11
    pulse_busy_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_en_o |-> (busy_o && !verify_o));
endmodule

bind fpe_pulse_seq fpe_pulse_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .pulse_en_o (pulse_en_o),
    .verify_o   (verify_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
);

// File: tb/fpe_pulse_seq_bench.sv
module fpe_pulse_seq_bench;

    typedef struct packed {
        logic        erase;
        logic [15:0] plen;
        logic [15:0] elen;
        logic [15:0] pdly;
        logic [15:0] edly;
        logic [7:0]  maxp;
        logic [7:0]  marg;
        logic [7:0]  tgt;
        logic [7:0]  need;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd3, 16'd9, 16'd2, 16'd5, 8'd8, 8'd2, 8'h5A, 8'd3},
        '{1'b1, 16'd3, 16'd9, 16'd2, 16'd5, 8'd8, 8'd1, 8'hFF, 8'd2},
        '{1'b0, 16'd1, 16'd1, 16'd1, 16'd1, 8'd4, 8'd0, 8'h33, 8'd1},
        '{1'b1, 16'd4, 16'd6, 16'd3, 16'd2, 8'd3, 8'd2, 8'hF0, 8'd5},
        '{1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 8'd0, 8'd1, 8'h81, 8'd1},
        '{1'b0, 16'd2, 16'd7, 16'd0, 16'd4, 8'd0, 8'd0, 8'h0F, 8'd2},
        '{1'b1, 16'd2, 16'd1, 16'd7, 16'd1, 8'd5, 8'd3, 8'hC3, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        erase_i = 1'b0;
    logic [15:0] prog_len_i = '0, erase_len_i = '0, prog_dly_i = '0, erase_dly_i = '0;
    logic [7:0]  max_pulses_i = '0, margin_i = '0, target_i = '0;
    logic [7:0]  rd_data_i;
    logic        pulse_en_o, verify_o, busy_o, done_o, fail_o;

    int nchk = 0;
    int nfail = 0;

    // behavioural cell and monitors
    int   seen = 0, need_m = 1, exp_l = 1, exp_d = 1;
    int   run = 0, since_fall = 0, werr = 0, gerr = 0, nver = 0;
    logic [7:0] tgt_m = '0;
    logic prev_pe = 1'b0;

    assign rd_data_i = (seen >= need_m) ? tgt_m : ~tgt_m;

    always #4 clk = ~clk;

    fpe_pulse_seq u_fpe_pulse_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .erase_i(erase_i),
        .prog_len_i(prog_len_i), .erase_len_i(erase_len_i),
        .prog_dly_i(prog_dly_i), .erase_dly_i(erase_dly_i),
        .max_pulses_i(max_pulses_i), .margin_i(margin_i),
        .target_i(target_i), .rd_data_i(rd_data_i),
        .pulse_en_o(pulse_en_o), .verify_o(verify_o), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o)
    );

    always @(negedge clk) begin
        if (pulse_en_o) begin
            if (!prev_pe) begin
                seen = seen + 1;
                run  = 0;
            end
            run = run + 1;
            since_fall = 0;
        end else begin
            if (prev_pe && run != exp_l) werr = werr + 1;
            since_fall = since_fall + 1;
        end
        if (verify_o) begin
            nver = nver + 1;
            if (since_fall != exp_d + 1) gerr = gerr + 1;
        end
        prev_pe = pulse_en_o;
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int one_min(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic apply(input vec_t v);
        erase_i      = v.erase;
        prog_len_i   = v.plen;
        erase_len_i  = v.elen;
        prog_dly_i   = v.pdly;
        erase_dly_i  = v.edly;
        max_pulses_i = v.maxp;
        margin_i     = v.marg;
        target_i     = v.tgt;
    endtask

    task automatic run_case(input vec_t v, input bit poke, input bit scramble, input string tag);
        int l, d, mx, t, cyc;
        bit pass;
        l    = one_min(v.erase ? int'(v.elen) : int'(v.plen));
        d    = one_min(v.erase ? int'(v.edly) : int'(v.pdly));
        mx   = one_min(int'(v.maxp));
        pass = int'(v.need) <= mx;
        t    = pass ? int'(v.need) * (l + d + 1) + int'(v.marg) * (l + d) : mx * (l + d + 1);
        @(negedge clk); #1;
        seen = 0; nver = 0; werr = 0; gerr = 0; run = 0; since_fall = 0;
        need_m = int'(v.need); tgt_m = v.tgt; exp_l = l; exp_d = d;
        apply(v);
        start_i = 1'b1;
        @(negedge clk);
        cyc = 1;
        start_i = 1'b0;
        // R2: accepted start shows busy and pulse next cycle
        chk({tag, " R2 busy"}, int'(busy_o), 1);
        chk({tag, " R2 pulse"}, int'(pulse_en_o), 1);
        while (!done_o && !fail_o && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            start_i = poke && (cyc == 3);
            if (scramble && cyc == 2) begin
                erase_i = ~v.erase; prog_len_i = 16'd11; erase_len_i = 16'd13;
                prog_dly_i = 16'd9; erase_dly_i = 16'd8; max_pulses_i = 8'd1;
                margin_i = 8'd7; target_i = ~v.tgt;
            end
        end
        start_i = 1'b0;
        #1;
        chk({tag, pass ? " R6 done" : " R7 fail"}, int'(pass ? done_o : fail_o), 1);
        chk({tag, " R6 R7 end cycle"}, cyc, 1 + t);
        chk({tag, " R6 pulses"}, seen, pass ? int'(v.need) + int'(v.marg) : mx);
        chk({tag, " R5 verifies"}, nver, pass ? int'(v.need) : mx);
        chk({tag, " R3 width errors"}, werr, 0);
        chk({tag, " R4 gap errors"}, gerr, 0);
        chk({tag, " R8 busy at end"}, int'(busy_o), 0);
        // R9: start in the done/fail cycle is ignored
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " R8 single end"}, int'(done_o || fail_o), 0);
        chk({tag, " R9 no restart"}, int'(busy_o || pulse_en_o), 0);
    endtask

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pulse", int'(pulse_en_o), 0);
        chk("R1 verify", int'(verify_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done/fail", int'(done_o || fail_o), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_case(VECS[i], 1'b0, 1'b0, $sformatf("vec%0d", i));
        end

        // R9: start strobed while busy
        run_case(VECS[0], 1'b1, 1'b0, "busy-start R9");
        // R10: configuration changed mid-sequence
        run_case(VECS[6], 1'b0, 1'b1, "scramble R10");
        run_case(VECS[3], 1'b0, 1'b1, "scramble-fail R10");

        // R1: reset in the middle of a pulse
        @(negedge clk);
        apply(VECS[1]);
        need_m = 9;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk("R11 pulse while busy", int'(pulse_en_o && busy_o), 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run pulse", int'(pulse_en_o), 0);
        chk("R1 mid-run busy", int'(busy_o), 0);
        rst = 1'b0;
        run_case(VECS[2], 1'b0, 1'b0, "after-reset");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule